// File: doc/BRIEF.md
# Fall-Through FIFO with Strobe/Flag Handshake

This block is a first-in first-out buffer, 64 words of 5 bits by default, in which every word moves toward the output on its own. Storage is a chain of slots. The first slot is an input stage and the last slot is an output stage. Between them sits a main chain of DEPTH-2 slots. A word advances one slot per clock whenever the slot ahead of it is empty. An emptied slot travels back toward the input one slot per clock.

The write side is a stream with a level strobe (`shift_in`) and a ready flag (`in_ready`). Back-pressure works like this: a word is taken only while `in_ready` is high. A strobe raised while the input stage is occupied is ignored. A captured word stays in the input stage while the strobe stays high and moves on after the strobe is sampled low.

The read side mirrors this with `shift_out` and `out_ready`. The word on `dout` is valid while `out_ready` is high. Raising `shift_out` claims the word, and lowering it releases the output stage for the next word. If either strobe is held high, the transfer completes by itself. This lets one unit's `out_ready` drive another unit's `shift_in` directly, with no glue logic between them.

Strobes are sampled on the rising clock edge. An active-low reset clears the buffer asynchronously. The output-enable input is registered onto `dout_en`, which marks when the data bus counts as driven; it does not touch the stored words.

Top module: `ft_fifo`

## Requirements
- R1: In reset and after it, `in_ready`=1, `out_ready`=0, `dout`=0 and `dout_en`=0.
- R2: If `shift_in` and `in_ready` are both high at a clock edge, `din` is captured and `in_ready` is 0 after that edge.
- R3: A captured word does not leave the input stage while `shift_in` stays high, so an empty buffer keeps `out_ready`=0.
- R4: Into an empty buffer, `out_ready` rises exactly DEPTH-1 clock edges after the first edge that samples `shift_in` low following the capture (63 for DEPTH=64).
- R5: Words leave on `dout` in the order they were captured, each valid while `out_ready`=1.
- R6: If `shift_out` and `out_ready` are both high at an edge, `out_ready` is 0 after that edge. The output stage is freed at the next edge that samples `shift_out` low.
- R7: Once DEPTH words are held, `in_ready` stays 0 and further `shift_in` pulses store nothing; draining then returns exactly DEPTH words.
- R8: `shift_out` while `out_ready`=0 has no effect. `dout` changes only in a cycle where `out_ready`=1, so the last word remains on `dout` after the buffer empties.
- R9: With `shift_out` held high on an empty buffer, an arriving word raises `out_ready` for exactly one cycle and is then consumed without further strobing.
- R10: With `shift_in` held high on a full buffer, one read makes `in_ready` high for exactly one cycle, and the word on `din` is then captured.
- R11: Asserting `rst_n` low empties a full buffer at once, without a clock edge: `in_ready`=1, `out_ready`=0, `dout`=0.
- R12: `dout_en` equals the inverse of `oe_n` from the previous edge. `oe_n` changes neither `dout` nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| shift_in | input | 1 | Write strobe, level sampled at clock edge |
| din | input | W | Write data |
| in_ready | output | 1 | Input stage empty, a word can be taken |
| shift_out | input | 1 | Read strobe, level sampled at clock edge |
| dout | output | W | Output stage word |
| out_ready | output | 1 | Valid unclaimed word on `dout` |
| oe_n | input | 1 | Active-low output enable |
| dout_en | output | 1 | Registered enable: `dout` counts as driven |

## Verification
The bench builds the block with its defaults, W=5 and DEPTH=64, so the full 63-edge ripple and the full bubble-up path are measured as exact cycle counts rather than scaled down. A complete fill and drain takes a few hundred cycles. Each fill cycles through all 32 data values twice. The two held-strobe cases are run at the exact full and empty boundaries. A reference queue supplies the expected order.

// File: rtl/ft_fifo_pkg.sv
`timescale 1ns/1ps
package ft_fifo_pkg;
  localparam int unsigned FT_WIDTH_DEF = 5;
  localparam int unsigned FT_DEPTH_DEF = 64;

  // output stage occupancy
  typedef enum logic [1:0] {
    OS_EMPTY = 2'd0,
    OS_SHOW  = 2'd1,
    OS_HELD  = 2'd2
  } ft_out_e;
endpackage

// File: rtl/ft_in_stage.sv
`timescale 1ns/1ps
module ft_in_stage #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_in,
  input  logic [W-1:0] din,
  input  logic         head_free,
  output logic         in_ready,
  output logic         offer,
  output logic [W-1:0] word
);
  logic         occ;
  logic         fresh;   // captured during the current strobe-high phase
  logic [W-1:0] hold;
  logic         capture;
  logic         hand;

  assign capture  = shift_in & ~occ;
  assign offer    = occ & (~fresh | ~shift_in);
  assign hand     = offer & head_free;
  assign in_ready = ~occ;
  assign word     = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ   <= 1'b0;
      fresh <= 1'b0;
      hold  <= '0;
    end else begin
      if (capture) begin
        occ  <= 1'b1;
        hold <= din;
      end else if (hand) begin
        occ <= 1'b0;
      end
      if (capture)        fresh <= 1'b1;
      else if (!shift_in) fresh <= 1'b0;
    end
  end
endmodule

// File: rtl/ft_chain.sv
`timescale 1ns/1ps
module ft_chain #(
  parameter int unsigned W = 5,
  parameter int unsigned N = 62
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_offer,
  input  logic [W-1:0] up_word,
  output logic         head_free,
  output logic         tail_valid,
  output logic [W-1:0] tail_word,
  input  logic         tail_free
);
  logic [N-1:0] occ;
  logic [N-1:0] src_v;
  logic [N-1:0] dn_free;
  logic [N-1:0] load;
  logic [N-1:0] leave;
  logic [W-1:0] word  [N];
  logic [W-1:0] src_d [N];

  for (genvar i = 0; i < N; i++) begin : g_link
    if (i == 0) begin : g_head
      assign src_v[i] = up_offer;
      assign src_d[i] = up_word;
    end else begin : g_body
      assign src_v[i] = occ[i-1];
      assign src_d[i] = word[i-1];
    end
    if (i == N-1) begin : g_tail
      assign dn_free[i] = tail_free;
    end else begin : g_mid
      assign dn_free[i] = ~occ[i+1];
    end
    assign load[i]  = src_v[i] & ~occ[i];
    assign leave[i] = occ[i] & dn_free[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
      for (int k = 0; k < N; k++) word[k] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (load[k]) begin
          occ[k]  <= 1'b1;
          word[k] <= src_d[k];
        end else if (leave[k]) begin
          occ[k] <= 1'b0;
        end
      end
    end
  end

  assign head_free  = ~occ[0];
  assign tail_valid = occ[N-1];
  assign tail_word  = word[N-1];
endmodule

// File: rtl/ft_out_stage.sv
`timescale 1ns/1ps
module ft_out_stage
  import ft_fifo_pkg::*;
#(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_out,
  input  logic         arr_valid,
  input  logic [W-1:0] arr_word,
  output logic         free,
  output logic         out_ready,
  output logic [W-1:0] dout
);
  ft_out_e      state;
  logic         late;   // word arrived while the read strobe was already high
  logic [W-1:0] q;

  assign free      = (state == OS_EMPTY);
  assign out_ready = (state == OS_SHOW);
  assign dout      = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= OS_EMPTY;
      late  <= 1'b0;
      q     <= '0;
    end else begin
      case (state)
        OS_EMPTY: if (arr_valid) begin
          state <= OS_SHOW;
          q     <= arr_word;
          late  <= shift_out;
        end
        OS_SHOW: begin
          if (shift_out) state <= OS_HELD;
          else           late  <= 1'b0;
        end
        OS_HELD: if (!shift_out || late) begin
          state <= OS_EMPTY;
          late  <= 1'b0;
        end
        default: state <= OS_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/ft_fifo.sv
`timescale 1ns/1ps
module ft_fifo
  import ft_fifo_pkg::*;
#(
  parameter int unsigned W     = FT_WIDTH_DEF,
  parameter int unsigned DEPTH = FT_DEPTH_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_in,
  input  logic [W-1:0] din,
  output logic         in_ready,
  input  logic         shift_out,
  output logic [W-1:0] dout,
  output logic         out_ready,
  input  logic         oe_n,
  output logic         dout_en
);
  localparam int unsigned MID = DEPTH - 2;

  logic         in_offer;
  logic [W-1:0] in_word;
  logic         head_free;
  logic         tail_valid;
  logic [W-1:0] tail_word;
  logic         out_free;

  ft_in_stage #(.W(W)) u_in (
    .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .din(din),
    .head_free(head_free), .in_ready(in_ready),
    .offer(in_offer), .word(in_word)
  );

  ft_chain #(.W(W), .N(MID)) u_chain (
    .clk(clk), .rst_n(rst_n), .up_offer(in_offer), .up_word(in_word),
    .head_free(head_free), .tail_valid(tail_valid),
    .tail_word(tail_word), .tail_free(out_free)
  );

  ft_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .shift_out(shift_out),
    .arr_valid(tail_valid), .arr_word(tail_word),
    .free(out_free), .out_ready(out_ready), .dout(dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_en <= 1'b0;
    else        dout_en <= ~oe_n;
  end
endmodule

// File: rtl/ft_fifo_chk.sv
`timescale 1ns/1ps
module ft_fifo_chk #(
  parameter int unsigned W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         shift_in,
  input logic         in_ready,
  input logic         shift_out,
  input logic         out_ready,
  input logic [W-1:0] dout,
  input logic         oe_n,
  input logic         dout_en
);
  // R2
  capture_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_in && in_ready |=> !in_ready);

  // R6
  claim_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_out && out_ready |=> !out_ready);

  // R8
  dout_moves_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> out_ready);

  // R12
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> dout_en);

  // R12
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dout_en);

  // R11
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |-> (in_ready && !out_ready && dout == '0 && !dout_en));
endmodule

bind ft_fifo ft_fifo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .in_ready(in_ready),
  .shift_out(shift_out), .out_ready(out_ready), .dout(dout),
  .oe_n(oe_n), .dout_en(dout_en)
);

// File: tb/ft_fifo_test.sv
`timescale 1ns/1ps
module ft_fifo_test;
  localparam int W = 5;
  localparam int D = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         si = 1'b0;
  logic         so = 1'b0;
  logic         oe_n = 1'b1;
  logic [W-1:0] din = '0;
  logic         in_ready;
  logic         out_ready;
  logic         dout_en;
  logic [W-1:0] dout;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] mq[$];

  always #2 clk = ~clk;

  ft_fifo #(.W(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .shift_in(si), .din(din), .in_ready(in_ready),
    .shift_out(so), .dout(dout), .out_ready(out_ready),
    .oe_n(oe_n), .dout_en(dout_en)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic push(input logic [W-1:0] w);
    int g = 0;
    while (!in_ready && g < 500) begin step(); g++; end
    si = 1'b1; din = w;
    step();
    chk("R2 in_ready after capture", int'(in_ready), 0);
    si = 1'b0;
    step();
    mq.push_back(w);
  endtask

  task automatic pop();
    logic [W-1:0] e;
    int g = 0;
    while (!out_ready && g < 500) begin step(); g++; end
    e = mq.pop_front();
    chk("R5 word order", int'(dout), int'(e));
    so = 1'b1;
    step();
    chk("R6 out_ready after claim", int'(out_ready), 0);
    so = 1'b0;
    step();
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    int hits;
    logic [W-1:0] snap;
    #1;
    // R1 during reset
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_ready", int'(out_ready), 0);
    chk("R1 dout", int'(dout), 0);
    chk("R1 dout_en", int'(dout_en), 0);
    #4 rst_n = 1'b1;
    step();
    chk("R1 in_ready after release", int'(in_ready), 1);

    // R3 / R4: hold then ripple latency
    si = 1'b1; din = 5'h15;
    step();
    chk("R2 capture", int'(in_ready), 0);
    repeat (5) step();
    chk("R3 held word stays", int'(out_ready), 0);
    si = 1'b0;
    n = 0;
    do begin step(); n++; end while (!out_ready && n < 200);
    chk("R4 ripple edges", n, D - 1);
    mq.push_back(5'h15);
    pop();

    // R8: read strobe on empty buffer
    so = 1'b1; step(); so = 1'b0; step(); step();
    chk("R8 out_ready stays low", int'(out_ready), 0);
    chk("R8 last word held", int'(dout), 'h15);

    // R7: fill with all data values twice
    for (int v = 0; v < D; v++) push(W'(v * 7 + 3));
    repeat (80) step();
    chk("R7 full in_ready", int'(in_ready), 0);
    chk("R7 full out_ready", int'(out_ready), 1);
    si = 1'b1; din = 5'h0A; step();
    chk("R7 overflow ignored", int'(in_ready), 0);
    si = 1'b0; step();

    // R10: held write strobe while full
    si = 1'b1; din = 5'h0B;
    pop();
    hits = 0;
    repeat (150) begin step(); if (in_ready) hits++; end
    chk("R10 in_ready pulse cycles", hits, 1);
    mq.push_back(5'h0B);
    si = 1'b0; step();

    // drain: exactly DEPTH words in order
    while (mq.size() > 0) pop();
    repeat (80) step();
    chk("R7 nothing extra stored", int'(out_ready), 0);

    // R9: held read strobe while empty
    so = 1'b1;
    push(5'h1C);
    hits = 0;
    repeat (100) begin step(); if (out_ready) hits++; end
    chk("R9 out_ready pulse cycles", hits, 1);
    chk("R9 consumed word on dout", int'(dout), 'h1C);
    void'(mq.pop_front());
    so = 1'b0;
    repeat (3) step();
    chk("R9 buffer empty", int'(out_ready), 0);

    // R12: output enable
    snap = dout;
    oe_n = 1'b0; step();
    chk("R12 dout_en on", int'(dout_en), 1);
    chk("R12 dout untouched", int'(dout), int'(snap));
    chk("R12 in_ready untouched", int'(in_ready), 1);
    chk("R12 out_ready untouched", int'(out_ready), 0);
    oe_n = 1'b1; step();
    chk("R12 dout_en off", int'(dout_en), 0);

    // R11: reset while full
    for (int v = 0; v < D; v++) push(W'(31 - (v % 32)));
    repeat (80) step();
    chk("R11 full before reset", int'(out_ready), 1);
    rst_n = 1'b0;
    #1;
    chk("R11 in_ready", int'(in_ready), 1);
    chk("R11 out_ready", int'(out_ready), 0);
    chk("R11 dout", int'(dout), 0);
    mq.delete();
    step();
    rst_n = 1'b1;
    repeat (80) step();
    chk("R11 stays empty", int'(out_ready), 0);
    push(5'h09);
    pop();

    summary();
  end
endmodule